// File: doc/BRIEF.md
# Tiled Display Memory Write Port

This block sits between a host microcontroller and the display memory of one panel driver core. The memory holds a 64-row by 64-column monochrome image as 8-bit cells: each cell covers eight vertically adjacent pixels of one column. A row group is one such band of eight rows. The host sends one byte per write over a parallel bus, with a global row-group address and a global column address. Scan logic fetches stored bytes through a separate read port.

Up to sixteen identical cores can share one host bus and act as one larger panel, four tiles high and four tiles wide. A 4-bit strap gives each core its place in that grid. A core stores a byte only when the upper address bits match its strap. It then uses the lower address bits as the local cell address. A busy output tells the host when the core cannot take a write. A sticky error flag records every write that the core dropped because it was busy. After reset the core clears its whole memory to zero, one cell per cycle, before it takes any write.

Top module: `disp_ram_host_if`

## Requirements
- R1: While `rst_n` is low, `busy` is 1 and `wr_err` is 0 from the next clock edge on, and a write presented during that time changes no memory cell.
- R2: After `rst_n` goes high, the memory is cleared one cell per cycle. `busy` falls at the 512th rising edge after the release, and from then on every cell reads 0 until it is written.
- R3: A write is accepted when `host_we` is high, `busy` is low and the tile matches. On acceptance the byte is stored at local index `host_row[2:0]*64 + host_col[5:0]`.
- R4: The tile matches when `host_row[4:3]` equals `tile_sel[1:0]` (row-cascade position) and `host_col[7:6]` equals `tile_sel[3:2]` (column-cascade position). A write that does not match changes no cell, does not raise `busy` and does not set `wr_err`.
- R5: After each accepted write, `busy` is high for exactly one cycle.
- R6: A matching write presented while `busy` is high is dropped, and it sets `wr_err`. `wr_err` then stays set until reset.
- R7: `scan_data` shows the cell at index `scan_row*64 + scan_col` one cycle after that address is presented.
- R8: When a scan read and an accepted write hit the same cell in the same cycle, `scan_data` returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| tile_sel | input | 4 | Grid position strap: [1:0] row-cascade, [3:2] column-cascade |
| host_we | input | 1 | Host write request |
| host_row | input | 5 | Global row-group address |
| host_col | input | 8 | Global column address |
| host_data | input | 8 | Display byte to store |
| busy | output | 1 | High while the core cannot accept a write |
| wr_err | output | 1 | Sticky flag for a write dropped while busy |
| scan_row | input | 3 | Scan readout local row group |
| scan_col | input | 6 | Scan readout local column |
| scan_data | output | 8 | Registered readout byte |

## Verification
The bench builds the core with its default sizes: eight row groups, sixty-four columns and a 2+2-bit cascade field. This lets it run the full 512-cycle clear and reach the last cell of the memory. Between two resets the tile strap changes from a middle grid position to the far corner. This covers both matching and non-matching values in each cascade field. The bench also sends back-to-back writes, same-cell collisions between scan and write, and writes addressed to neighbouring tiles.

// File: rtl/disp_ram_pkg.sv
// Shared sizes and the write-request type for the tiled display memory port.
// Assumes row groups and columns are powers of two.
package disp_ram_pkg;
    localparam int ROW_GRP = 8;
    localparam int COLS    = 64;
    localparam int CAS_W   = 2;
    localparam int DATA_W  = 8;
    localparam int RG_W    = $clog2(ROW_GRP);
    localparam int CL_W    = $clog2(COLS);
    localparam int DEPTH   = ROW_GRP * COLS;
    localparam int ADDR_W  = $clog2(DEPTH);

    typedef struct packed {
        logic [RG_W-1:0]   row;
        logic [CL_W-1:0]   col;
        logic [DATA_W-1:0] data;
    } wr_req_t;
endpackage

// File: rtl/disp_tile_decode.sv
// Tile decode: compares the cascade bits of a global address with the strap
// and passes on the local part. Assumes the strap is stable outside reset.
module disp_tile_decode #(
    parameter int RG_W  = 3,
    parameter int CL_W  = 6,
    parameter int CAS_W = 2
) (
    input  logic [2*CAS_W-1:0]    tile_sel,
    input  logic [RG_W+CAS_W-1:0] g_row,
    input  logic [CL_W+CAS_W-1:0] g_col,
    output logic                  hit,
    output logic [RG_W-1:0]       l_row,
    output logic [CL_W-1:0]       l_col
);
    localparam int AXES = 2;
    logic [AXES-1:0]      axis_ok;
    logic [CAS_W-1:0]     g_cas [AXES];

    assign g_cas[0] = g_row[RG_W +: CAS_W];
    assign g_cas[1] = g_col[CL_W +: CAS_W];

    // One comparator per axis: axis 0 uses the low strap field, axis 1 the high one.
    for (genvar a = 0; a < AXES; a++) begin : g_axis
        assign axis_ok[a] = (g_cas[a] == tile_sel[a*CAS_W +: CAS_W]);
    end

    // The core is addressed only when both axes match.
    always_comb begin
        hit   = &axis_ok;
        l_row = g_row[RG_W-1:0];
        l_col = g_col[CL_W-1:0];
    end
endmodule

// File: rtl/disp_wr_ctrl.sv
// Write control: runs the sequential clear after reset, accepts host
// writes, raises busy and records dropped writes. Assumes synchronous active-low reset.
module disp_wr_ctrl #(
    parameter int DEPTH  = 512,
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit_we,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              busy,
    output logic              wr_err,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_din
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    logic              clearing;
    logic [ADDR_W-1:0] clr_cnt;
    logic              pulse;
    logic              accept;

    // Busy is high during the clear and in the cycle after an accepted write.
    always_comb begin
        busy   = clearing | pulse;
        accept = rst_n & hit_we & ~busy;
    end

    // Clear walk, busy pulse and sticky error state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clearing <= 1'b1;
            clr_cnt  <= '0;
            pulse    <= 1'b0;
            wr_err   <= 1'b0;
        end else begin
            if (clearing) begin
                clr_cnt <= clr_cnt + 1'b1;
                if (clr_cnt == LAST) clearing <= 1'b0;
            end
            pulse <= accept;
            if (hit_we && busy) wr_err <= 1'b1;
        end
    end

    // Memory port mux: the clear has priority; it only runs while busy is high.
    always_comb begin
        mem_we   = rst_n & (clearing | accept);
        mem_addr = clearing ? clr_cnt : wr_addr;
        mem_din  = clearing ? '0 : wr_data;
    end
endmodule

// File: rtl/disp_dram.sv
// Display memory: one write port and one registered read port. A read
// and a write to the same cell in one cycle return the old contents.
module disp_dram #(
    parameter int DEPTH  = 512,
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] cells [DEPTH];

    // Write port.
    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    // Read port, one cycle latency, read before write.
    always_ff @(posedge clk) begin
        rdata <= cells[raddr];
    end
endmodule

// File: rtl/disp_ram_host_if.sv
// Top of the tiled display memory write port. A host write is stored
// only when its address falls in this core's tile. The scan side reads
// through a registered port. Assumes tile_sel changes only during reset.
module disp_ram_host_if
    import disp_ram_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2*CAS_W-1:0]   tile_sel,
    input  logic                 host_we,
    input  logic [RG_W+CAS_W-1:0] host_row,
    input  logic [CL_W+CAS_W-1:0] host_col,
    input  logic [DATA_W-1:0]    host_data,
    output logic                 busy,
    output logic                 wr_err,
    input  logic [RG_W-1:0]      scan_row,
    input  logic [CL_W-1:0]      scan_col,
    output logic [DATA_W-1:0]    scan_data
);
    logic              hit;
    wr_req_t           req;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_din;
    logic [ADDR_W-1:0] rd_addr;

    disp_tile_decode #(.RG_W(RG_W), .CL_W(CL_W), .CAS_W(CAS_W)) u_dec (
        .tile_sel (tile_sel),
        .g_row    (host_row),
        .g_col    (host_col),
        .hit      (hit),
        .l_row    (req.row),
        .l_col    (req.col)
    );

    // Data travels with the local address.
    assign req.data = host_data;
    // Scan index is row-major.
    assign rd_addr  = {scan_row, scan_col};

    disp_wr_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_we   (host_we & hit),
        .wr_addr  ({req.row, req.col}),
        .wr_data  (req.data),
        .busy     (busy),
        .wr_err   (wr_err),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_din  (mem_din)
    );

    disp_dram #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_addr),
        .wdata (mem_din),
        .raddr (rd_addr),
        .rdata (scan_data)
    );
endmodule

// File: rtl/disp_ram_host_if_chk.sv
// Port-level protocol checker for the tiled display memory write port, bound to the top.
module disp_ram_host_if_chk
    import disp_ram_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic [2*CAS_W-1:0]    tile_sel,
    input logic                  host_we,
    input logic [RG_W+CAS_W-1:0] host_row,
    input logic [CL_W+CAS_W-1:0] host_col,
    input logic                  busy,
    input logic                  wr_err
);
    logic match;
    assign match = host_we
                 && (host_row[RG_W +: CAS_W] == tile_sel[CAS_W-1:0])
                 && (host_col[CL_W +: CAS_W] == tile_sel[2*CAS_W-1:CAS_W]);

    // R1
    reset_state_chk: assert property (@(posedge clk) !rst_n |=> (busy && !wr_err));

    // R5
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !busy) |=> busy);

    // R4
    idle_stays_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !match) |=> !busy);

    // R6
    drop_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match && busy) |=> wr_err);

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |=> wr_err);

    // R4
    miss_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_err && !match) |=> !wr_err);
endmodule

bind disp_ram_host_if disp_ram_host_if_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tile_sel (tile_sel),
    .host_we  (host_we),
    .host_row (host_row),
    .host_col (host_col),
    .busy     (busy),
    .wr_err   (wr_err)
);

// File: tb/tb_disp_ram_host_if.sv
module tb_disp_ram_host_if;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] tile_sel = 4'b0110;
    logic       host_we = 1'b0;
    logic [4:0] host_row = '0;
    logic [7:0] host_col = '0;
    logic [7:0] host_data = '0;
    logic       busy, wr_err;
    logic [2:0] scan_row = '0;
    logic [5:0] scan_col = '0;
    logic [7:0] scan_data;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    disp_ram_host_if dut (.*);

    // Behavioural reference model, updated on each rising edge.
    byte unsigned m_mem [512];
    bit  m_clearing = 1'b1;
    int  m_clr = 0;
    bit  m_pulse = 1'b0;
    bit  m_err = 1'b0;
    bit  m_busy = 1'b1;
    byte unsigned m_scan;
    bit  m_scan_ok = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_clearing = 1'b1; m_clr = 0; m_pulse = 1'b0; m_err = 1'b0;
            m_scan_ok = 1'b0;
        end else begin
            automatic bit hit = host_we && host_row[4:3] == tile_sel[1:0]
                                        && host_col[7:6] == tile_sel[3:2];
            automatic bit was_busy = m_clearing || m_pulse;
            m_scan_ok = !m_clearing;
            m_scan = m_mem[int'(scan_row) * 64 + int'(scan_col)];
            if (m_clearing) begin
                m_mem[m_clr] = 8'h00;
                if (m_clr == 511) m_clearing = 1'b0;
                m_clr++;
            end
            if (hit && was_busy) m_err = 1'b1;
            if (hit && !was_busy)
                m_mem[int'(host_row[2:0]) * 64 + int'(host_col[5:0])] = host_data;
            m_pulse = hit && !was_busy;
        end
        m_busy = m_clearing || m_pulse;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, on the falling edge.
    always @(negedge clk) begin
        if (rst_n !== 1'b0 || $time > 20) begin
            check(busy === m_busy, "R1/R2/R5 busy vs model", int'(busy), int'(m_busy));
            check(wr_err === m_err, "R1/R6 wr_err vs model", int'(wr_err), int'(m_err));
            if (m_scan_ok && rst_n)
                check(scan_data === m_scan, "R7/R8 scan_data vs model", int'(scan_data), int'(m_scan));
        end
    end

    task automatic drive(input bit we, input logic [4:0] r, input logic [7:0] c,
                         input logic [7:0] d, input logic [2:0] sr, input logic [5:0] sc);
        @(negedge clk);
        host_we = we; host_row = r; host_col = c; host_data = d;
        scan_row = sr; scan_col = sc;
    endtask

    task automatic read_cell(input logic [2:0] sr, input logic [5:0] sc,
                             input logic [7:0] exp, input string req);
        drive(1'b0, '0, '0, '0, sr, sc);
        @(posedge clk); #1;
        check(scan_data === exp, req, int'(scan_data), int'(exp));
    endtask

    task automatic release_and_clear();
        int n = 0;
        @(negedge clk); rst_n = 1'b1;
        do begin @(posedge clk); #1; n++; end while (busy && n < 2000);
        // R2: busy falls at the 512th edge after release
        check(n == 512, "R2 clear length", n, 512);
    endtask

    initial begin : watchdog
        #2000000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state, and a matching write during reset is ignored
        drive(1'b1, 5'b10_001, 8'b01_000010, 8'hAA, 3'd1, 6'd2);
        drive(1'b1, 5'b10_001, 8'b01_000010, 8'hAA, 3'd1, 6'd2);
        @(posedge clk); #1;
        check(busy === 1'b1, "R1 busy in reset", int'(busy), 1);
        check(wr_err === 1'b0, "R1 err clear in reset", int'(wr_err), 0);
        drive(1'b0, '0, '0, '0, '0, '0);
        release_and_clear();
        // R1/R2: cell written during reset reads zero after clear
        read_cell(3'd1, 6'd2, 8'h00, "R1 reset write ignored");
        read_cell(3'd7, 6'd63, 8'h00, "R2 last cell cleared");
        read_cell(3'd0, 6'd0, 8'h00, "R2 first cell cleared");

        // R3/R7: accepted writes land at local index (tile row 2, col 1)
        drive(1'b1, 5'b10_000, 8'b01_000000, 8'h11, '0, '0);
        drive(1'b0, '0, '0, '0, '0, '0);
        drive(1'b1, 5'b10_111, 8'b01_111111, 8'hE7, '0, '0);
        drive(1'b0, '0, '0, '0, '0, '0);
        drive(1'b1, 5'b10_011, 8'b01_010101, 8'h5C, '0, '0);
        drive(1'b0, '0, '0, '0, '0, '0);
        read_cell(3'd0, 6'd0, 8'h11, "R3 write at index 0");
        read_cell(3'd7, 6'd63, 8'hE7, "R3 write at last index");
        read_cell(3'd3, 6'd21, 8'h5C, "R7 readout");

        // R4: writes to neighbouring tiles change nothing
        drive(1'b1, 5'b11_011, 8'b01_010101, 8'h99, '0, '0);
        @(posedge clk); #1;
        check(busy === 1'b0, "R4 row mismatch no busy", int'(busy), 0);
        drive(1'b1, 5'b10_011, 8'b10_010101, 8'h98, '0, '0);
        @(posedge clk); #1;
        check(busy === 1'b0, "R4 col mismatch no busy", int'(busy), 0);
        check(wr_err === 1'b0, "R4 mismatch no err", int'(wr_err), 0);
        read_cell(3'd3, 6'd21, 8'h5C, "R4 cell unchanged");

        // R5: one-cycle busy after accept
        drive(1'b1, 5'b10_010, 8'b01_000100, 8'h3A, '0, '0);
        @(posedge clk); #1;
        check(busy === 1'b1, "R5 busy after accept", int'(busy), 1);
        drive(1'b0, '0, '0, '0, '0, '0);
        @(posedge clk); #1;
        check(busy === 1'b0, "R5 busy lasts one cycle", int'(busy), 0);

        // R6: back-to-back write, second dropped, error sticky
        drive(1'b1, 5'b10_100, 8'b01_001000, 8'h71, '0, '0);
        drive(1'b1, 5'b10_101, 8'b01_001001, 8'h72, '0, '0);
        drive(1'b0, '0, '0, '0, '0, '0);
        @(posedge clk); #1;
        check(wr_err === 1'b1, "R6 err set on drop", int'(wr_err), 1);
        read_cell(3'd5, 6'd9, 8'h00, "R6 dropped write not stored");
        read_cell(3'd4, 6'd8, 8'h71, "R6 first write kept");
        for (int i = 0; i < 4; i++) drive(1'b0, '0, '0, '0, '0, '0);
        @(posedge clk); #1;
        check(wr_err === 1'b1, "R6 err sticky", int'(wr_err), 1);

        // R8: collision returns old contents, then new
        drive(1'b1, 5'b10_100, 8'b01_001000, 8'hC4, 3'd4, 6'd8);
        @(posedge clk); #1;
        check(scan_data === 8'h71, "R8 collision old data", int'(scan_data), 8'h71);
        drive(1'b0, '0, '0, '0, 3'd4, 6'd8);
        @(posedge clk); #1;
        check(scan_data === 8'hC4, "R8 new data next read", int'(scan_data), 8'hC4);

        // Corner tile: second reset with strap 4'b1111
        @(negedge clk); rst_n = 1'b0; tile_sel = 4'b1111;
        drive(1'b0, '0, '0, '0, '0, '0);
        @(posedge clk); #1;
        check(wr_err === 1'b0, "R6 err cleared by reset", int'(wr_err), 0);
        release_and_clear();
        drive(1'b1, 5'b11_111, 8'b11_111111, 8'h5A, '0, '0);
        drive(1'b1, 5'b10_111, 8'b11_111110, 8'h33, '0, '0);
        drive(1'b0, '0, '0, '0, '0, '0);
        check(wr_err === 1'b0, "R4 corner mismatch during busy no err", int'(wr_err), 0);
        read_cell(3'd7, 6'd63, 8'h5A, "R4 corner tile last cell");
        read_cell(3'd7, 6'd62, 8'h00, "R4 corner tile mismatch ignored");
        read_cell(3'd4, 6'd8, 8'h00, "R2 old data cleared by new reset");

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule